// File: doc/BRIEF.md
# Tuner Control Register Slave on a Two-Wire Bus

This block is the control-register front end of a broadcast tuner. It is a target on an I2C-compatible two-wire bus. SCL and SDA reach it already synchronised into a fast system clock, so it sees the bus as plain levels. It finds START and STOP conditions and compares the incoming address with a 7-bit value. Five bits of that value are fixed and two come from strap pins. It acknowledges matching address bytes and every byte written to it.

An internal register pointer is set by the first byte after a write address. The pointer advances after every data byte, in both directions. A master can therefore write a burst of registers, or set the pointer and then read a run of registers after a repeated START. The block holds eleven read/write configuration bytes and presents them to the analog side as one flat bus. It also has two read-only locations. One is a status byte with a power-on flag that clears when read, plus a live lock indicator. The other is a window into a small calibration ROM, selected by a field in one of the read/write registers.

SDA is driven as an open-drain enable, and the block never stretches the clock.

Top module: `tuner_i2c_regs`

## Requirements
- R1: A fall of SDA while SCL is high (START) starts a new address phase from any state, including in the middle of a transfer. A rise of SDA while SCL is high (STOP) returns the block to idle with SDA released.
- R2: The target address is {5'b11000, addr_strap[1], addr_strap[0]}, followed by the R/W bit (1 = read). On a match, sda_oe is high for the whole ninth clock. On a mismatch there is no acknowledge, and the rest of the transfer is ignored until the next START.
- R3: In a write transfer, the byte after the address loads the pointer. Each later byte is stored at the pointer, the pointer then advances by one, and every such byte is acknowledged.
- R4: After a repeated START with R/W = 1, bytes are sent MSB first, starting at the pointer. A master ACK advances the pointer and sends the next location. A master NACK releases SDA for the rest of the transfer.
- R5: After reset, register 0x00 is 0x12 and 0x01 is 0x50, which together give the 15-bit divider default 4688. Registers 0x02 to 0x0A are 0x00. Register k appears on cfg_flat[8k+7:8k].
- R6: Bit 7 of register 0x00 and bits 7:4 of register 0x09 always read 0, whatever is written to them.
- R7: Location 0x0C reads {por, lock_ind[2:0], 4'b0000}. por is 1 after reset and becomes 0 once that location has been sent on the bus.
- R8: Location 0x0B returns calibration ROM entry n, where n is register 0x09 bits 3:0. Entry n is CAL_ROM[8n+7:8n].
- R9: Writes to 0x0B, 0x0C and any pointer of 0x0D or above are acknowledged and discarded. Reads at pointers of 0x0D or above return 0x00.
- R10: sda_oe only turns on while SCL is low, at least one clock after the SCL falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| addr_strap | input | 2 | Address straps: bit 1 is address bit 1, bit 0 is address bit 0 |
| lock_ind | input | 3 | Live lock indicator shown in the status byte |
| sda_oe | output | 1 | 1 pulls SDA low |
| cfg_flat | output | 88 | Read/write registers 0x00 to 0x0A, byte k at bits 8k+7:8k |

## Verification
A wrong pointer or a wrong state in the byte sequencer shows up at the ports within one byte time. Either the next acknowledge is missing or misplaced on sda_oe, or the following byte lands in the wrong slice of cfg_flat, or the wrong byte is read back. A stuck power-on flag shows on the second read of the status byte. A bad ROM select shows on the first read of the window after the select is written. The bench therefore writes each location, reads it back through a repeated START, and compares the result with values worked out from the masking, ROM and status rules.

// File: rtl/tuner_i2c_pkg.sv
// Package: shared constants and the byte-sequencer state type for the
// tuner control-register slave. Assumes 8-bit bus bytes.
package tuner_i2c_pkg;
    localparam int BYTE_W = 8;
    localparam logic [4:0] ADDR_FIXED = 5'b11000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_PTR,
        ST_PACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_MACK
    } bus_state_t;
endpackage

// File: rtl/i2c_bus_events.sv
// Module: turns sampled SCL/SDA levels into one-cycle START, STOP,
// SCL-rise and SCL-fall events. Assumes the inputs are already
// synchronised to clk and that SCL is much slower than clk.
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_ev,
    output logic stop_ev,
    output logic rise_ev,
    output logic fall_ev
);
    logic scl_d, sda_d;

    // Keep the previous bus levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_i;
            sda_d <= sda_i;
        end
    end

    // Classify the change between the previous and current samples.
    always_comb begin
        start_ev = scl_d && scl_i && sda_d && !sda_i;
        stop_ev  = scl_d && scl_i && !sda_d && sda_i;
        rise_ev  = !scl_d && scl_i;
        fall_ev  = scl_d && !scl_i;
    end
endmodule

// File: rtl/i2c_byte_engine.sv
// Module: bus-side sequencer. It shifts address, pointer and data bytes
// in and out, drives acknowledges, and owns the auto-incrementing
// register pointer. Assumes no clock stretching is needed, since the
// read data is available combinationally.
module i2c_byte_engine
    import tuner_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              rise_ev,
    input  logic              fall_ev,
    input  logic [6:0]        dev_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              wr_en,
    output logic              rd_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] ptr,
    output logic              sda_oe
);
    bus_state_t        state;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txreg;
    logic              rw_q;
    logic              macked_q;
    logic              byte_full;

    assign byte_full = (cnt == 4'd8);
    assign wr_data   = shreg;

    // Strobes into the register file, timed on the SCL falling edge.
    always_comb begin
        wr_en = (state == ST_WDATA) && fall_ev && byte_full;
        rd_en = fall_ev && (((state == ST_AACK) && rw_q) ||
                            ((state == ST_MACK) && macked_q));
    end

    // Byte sequencer: shifting, acknowledges and pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            txreg    <= '0;
            rw_q     <= 1'b0;
            macked_q <= 1'b0;
            ptr      <= '0;
            sda_oe   <= 1'b0;
        end else if (start_ev) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else if (stop_ev) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (rise_ev) begin
                        shreg <= {shreg[BYTE_W-2:0], sda_i};
                        cnt   <= cnt + 4'd1;
                    end else if (fall_ev && byte_full) begin
                        if (state == ST_ADDR) begin
                            if (shreg[7:1] == dev_addr) begin
                                rw_q   <= shreg[0];
                                state  <= ST_AACK;
                                sda_oe <= 1'b1;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (state == ST_PTR) begin
                            ptr    <= shreg;
                            state  <= ST_PACK;
                            sda_oe <= 1'b1;
                        end else begin
                            ptr    <= ptr + 8'd1;
                            state  <= ST_WACK;
                            sda_oe <= 1'b1;
                        end
                    end
                end
                ST_AACK: begin
                    if (fall_ev) begin
                        cnt <= '0;
                        if (rw_q) begin
                            txreg  <= rd_data;
                            sda_oe <= ~rd_data[7];
                            state  <= ST_RDATA;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_PTR;
                        end
                    end
                end
                ST_PACK, ST_WACK: begin
                    if (fall_ev) begin
                        cnt    <= '0;
                        sda_oe <= 1'b0;
                        state  <= ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (rise_ev) begin
                        cnt <= cnt + 4'd1;
                    end else if (fall_ev) begin
                        if (byte_full) begin
                            sda_oe <= 1'b0;
                            state  <= ST_MACK;
                        end else begin
                            txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~txreg[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (rise_ev) begin
                        macked_q <= !sda_i;
                        if (!sda_i) ptr <= ptr + 8'd1;
                    end else if (fall_ev) begin
                        cnt <= '0;
                        if (macked_q) begin
                            txreg  <= rd_data;
                            sda_oe <= ~rd_data[7];
                            state  <= ST_RDATA;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state == ST_IDLE) && !sda_oe);

    assert_no_ack_mismatch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && fall_ev && byte_full && shreg[7:1] != dev_addr && !start_ev && !stop_ev)
        |=> !sda_oe);

    assert_ptr_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ptr == $past(ptr) + 8'd1);

    assert_oe_on_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);
endmodule

// File: rtl/tuner_reg_file.sv
// Module: the tuner register map. It holds the read/write configuration
// bytes with per-register masks, the status byte with a clear-on-read
// power-on flag, and the calibration ROM window. Assumes that rd_en
// marks the moment a location is sent on the bus.
module tuner_reg_file #(
    parameter int                        NUM_RW    = 11,
    parameter int                        ROM_AW    = 4,
    parameter logic [14:0]               N_DEFAULT = 15'd4688,
    parameter logic [8*(2**ROM_AW)-1:0]  CAL_ROM   = 128'hF0E1D2C3B4A5968778695A4B3C2D1E0F
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [7:0]          addr,
    input  logic [7:0]          wr_data,
    input  logic [2:0]          lock_ind,
    output logic [7:0]          rd_data,
    output logic [NUM_RW*8-1:0] cfg_flat
);
    localparam int ROM_SEL_REG   = NUM_RW - 2;
    localparam int ROM_DATA_ADDR = NUM_RW;
    localparam int STATUS_ADDR   = NUM_RW + 1;

    logic [NUM_RW-1:0][7:0] regq;
    logic                   por_q;
    logic [ROM_AW-1:0]      rom_sel;
    logic [7:0]             rom_byte;

    for (genvar k = 0; k < NUM_RW; k++) begin : g_reg
        localparam logic [7:0] RST_V  = (k == 0) ? {1'b0, N_DEFAULT[14:8]} :
                                        (k == 1) ? N_DEFAULT[7:0] : 8'h00;
        localparam logic [7:0] MASK_V = (k == 0) ? 8'h7F :
                                        (k == ROM_SEL_REG) ? 8'((1 << ROM_AW) - 1) : 8'hFF;
        logic [7:0] q;

        // One configuration byte: store masked bus writes.
        always_ff @(posedge clk) begin
            if (!rst_n)                            q <= RST_V;
            else if (wr_en && addr == 8'(k))       q <= wr_data & MASK_V;
        end

        assign regq[k]          = q;
        assign cfg_flat[8*k +: 8] = q;
    end

    assign rom_sel  = regq[ROM_SEL_REG][ROM_AW-1:0];
    assign rom_byte = CAL_ROM[{rom_sel, 3'b000} +: 8];

    // Power-on flag: set by reset, cleared when status is sent.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       por_q <= 1'b1;
        else if (rd_en && addr == 8'(STATUS_ADDR))        por_q <= 1'b0;
    end

    // Read mux over the whole pointer space; unmapped reads give zero.
    always_comb begin
        rd_data = 8'h00;
        for (int k = 0; k < NUM_RW; k++)
            if (addr == 8'(k)) rd_data = regq[k];
        if (addr == 8'(ROM_DATA_ADDR)) rd_data = rom_byte;
        if (addr == 8'(STATUS_ADDR))   rd_data = {por_q, lock_ind, 4'b0000};
    end

    assert_por_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 8'(STATUS_ADDR)) |=> !por_q);
endmodule

// File: rtl/tuner_i2c_regs.sv
// Module: top of the tuner control-register slave. It joins the bus
// event detector, the byte sequencer and the register map. Assumes
// SCL and SDA are already synchronised to clk.
module tuner_i2c_regs #(
    parameter int                        NUM_RW    = 11,
    parameter int                        ROM_AW    = 4,
    parameter logic [14:0]               N_DEFAULT = 15'd4688,
    parameter logic [8*(2**ROM_AW)-1:0]  CAL_ROM   = 128'hF0E1D2C3B4A5968778695A4B3C2D1E0F
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    input  logic [1:0]          addr_strap,
    input  logic [2:0]          lock_ind,
    output logic                sda_oe,
    output logic [NUM_RW*8-1:0] cfg_flat
);
    import tuner_i2c_pkg::*;

    logic       start_ev, stop_ev, rise_ev, fall_ev;
    logic       wr_en, rd_en;
    logic [7:0] wr_data, rd_data, ptr;
    logic [6:0] dev_addr;

    assign dev_addr = {ADDR_FIXED, addr_strap};

    i2c_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .rise_ev  (rise_ev),
        .fall_ev  (fall_ev)
    );

    i2c_byte_engine u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .rise_ev  (rise_ev),
        .fall_ev  (fall_ev),
        .dev_addr (dev_addr),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wr_data  (wr_data),
        .ptr      (ptr),
        .sda_oe   (sda_oe)
    );

    tuner_reg_file #(
        .NUM_RW    (NUM_RW),
        .ROM_AW    (ROM_AW),
        .N_DEFAULT (N_DEFAULT),
        .CAL_ROM   (CAL_ROM)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (ptr),
        .wr_data  (wr_data),
        .lock_ind (lock_ind),
        .rd_data  (rd_data),
        .cfg_flat (cfg_flat)
    );
endmodule

// File: tb/tuner_i2c_regs_tb.sv
`timescale 1ns/1ps
module tuner_i2c_regs_tb;
    localparam int Q = 10;
    localparam logic [7:0] WADDR = 8'hC4;
    localparam logic [7:0] RADDR = 8'hC5;
    // {pointer, value written, value expected on read-back}
    localparam logic [23:0] VEC [8] = '{
        24'h00_FF_7F,
        24'h01_A5_A5,
        24'h05_3C_3C,
        24'h09_F7_07,
        24'h0A_81_81,
        24'h0B_55_78,
        24'h0C_FF_D0,
        24'h20_44_00
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  addr_strap = 2'b10;
    logic [2:0]  lock_ind = 3'b101;
    logic        sda_oe;
    logic [87:0] cfg_flat;
    wire         sda_bus = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    int oe_bad = 0;
    logic oe_prev = 1'b0;

    always #2.5 clk = ~clk;

    tuner_i2c_regs u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .addr_strap (addr_strap),
        .lock_ind   (lock_ind),
        .sda_oe     (sda_oe),
        .cfg_flat   (cfg_flat)
    );

    // R10 monitor: an acknowledge or data drive must begin while SCL is low.
    always @(negedge clk) begin
        if (rst_n && sda_oe && !oe_prev && scl_m) oe_bad++;
        oe_prev <= sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic wbyte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq();
            scl_m = 1'b1; wq(); wq();
            scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        acked = ~sda_bus; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic rbyte(input logic mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wq();
            scl_m = 1'b1; wq();
            b[i] = sda_bus; wq();
            scl_m = 1'b0; wq();
        end
        sda_m = ~mack; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    task automatic write_reg(input logic [7:0] p, input logic [7:0] d, output logic ok);
        logic a0, a1, a2;
        bus_start();
        wbyte(WADDR, a0); wbyte(p, a1); wbyte(d, a2);
        bus_stop();
        ok = a0 & a1 & a2;
    endtask

    task automatic read_reg(input logic [7:0] p, output logic [7:0] d);
        logic a;
        bus_start();
        wbyte(WADDR, a); wbyte(p, a);
        bus_start();
        wbyte(RADDR, a);
        rbyte(1'b0, d);
        bus_stop();
    endtask

    function automatic logic [7:0] rom_entry(input int n);
        return {4'(n), 4'(15 - n)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic ok, a;
        logic [7:0] d, d2;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R5: reset values on the configuration bus.
        chk("R5 reg00", cfg_flat[7:0], 8'h12);
        chk("R5 reg01", cfg_flat[15:8], 8'h50);
        chk("R5 regs02-0A", cfg_flat[87:16], 72'h0);
        chk("R1 idle oe", sda_oe, 1'b0);

        // Table: write each location, then read it back via a repeated START (R3 R4 R6 R7 R8 R9).
        for (int v = 0; v < 8; v++) begin
            write_reg(VEC[v][23:16], VEC[v][15:8], ok);
            chk("R3 R9 write acked", ok, 1'b1);
            read_reg(VEC[v][23:16], d);
            chk("R4 R6 R7 R8 R9 read-back", d, VEC[v][7:0]);
        end
        chk("R6 reg00 bit7 on bus", cfg_flat[7], 1'b0);
        chk("R6 reg09 upper", cfg_flat[79:76], 4'h0);

        // R3: burst write with auto-increment.
        bus_start();
        wbyte(WADDR, a); wbyte(8'h02, a);
        wbyte(8'h0E, a); wbyte(8'hD8, a); wbyte(8'hE1, a);
        bus_stop();
        chk("R3 burst last ack", a, 1'b1);
        chk("R3 burst reg02", cfg_flat[23:16], 8'h0E);
        chk("R3 burst reg03", cfg_flat[31:24], 8'hD8);
        chk("R3 burst reg04", cfg_flat[39:32], 8'hE1);
        chk("R1 stop releases", sda_oe, 1'b0);

        // R4: burst read, master ACK then NACK.
        bus_start();
        wbyte(WADDR, a); wbyte(8'h03, a);
        bus_start();
        wbyte(RADDR, a);
        chk("R2 read address acked", a, 1'b1);
        rbyte(1'b1, d); rbyte(1'b0, d2);
        bus_stop();
        chk("R4 burst read first", d, 8'hD8);
        chk("R4 burst read second", d2, 8'hE1);

        // R2: wrong address is not acknowledged and changes nothing.
        bus_start();
        wbyte(8'hC0, a);
        chk("R2 mismatch no ack", a, 1'b0);
        wbyte(8'h02, a); wbyte(8'h99, a);
        bus_stop();
        chk("R2 mismatch ignored", cfg_flat[23:16], 8'h0E);

        // R2: other strap setting moves the address.
        addr_strap = 2'b01;
        bus_start();
        wbyte(8'hC2, a);
        bus_stop();
        chk("R2 strap 01 acked", a, 1'b1);
        addr_strap = 2'b10;

        // R8: ROM window at the top entry.
        write_reg(8'h09, 8'h0F, ok);
        read_reg(8'h0B, d);
        chk("R8 rom entry 15", d, rom_entry(15));

        // R7 R9: status after being read, then unmapped pointer.
        bus_start();
        wbyte(WADDR, a); wbyte(8'h0C, a);
        bus_start();
        wbyte(RADDR, a);
        rbyte(1'b1, d); rbyte(1'b0, d2);
        bus_stop();
        chk("R7 por cleared", d, 8'h50);
        chk("R9 unmapped read", d2, 8'h00);

        // R1: START in the middle of a write aborts it; next transfer works.
        bus_start();
        wbyte(WADDR, a); wbyte(8'h06, a);
        bus_start();
        wbyte(WADDR, a); wbyte(8'h07, a); wbyte(8'h3A, a);
        bus_stop();
        chk("R1 restart write reg07", cfg_flat[63:56], 8'h3A);
        chk("R1 restart reg06 untouched", cfg_flat[55:48], 8'h00);

        chk("R10 oe only while SCL low", oe_bad, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule